// File: doc/BRIEF.md
# Oscillator-Count Response Generator

This block turns a row of free-running oscillator signals into a response word for a physical unclonable function. A measurement begins with a start request. The block then raises a registered enable that releases every external oscillator on the same system-clock edge. It counts rising edges on each input over a window whose length is programmable, and it compares neighbouring counts.

Any input may be gated to a constant 0 instead of toggling. Its count then stays at zero, and it loses every comparison against a live oscillator. Only adjacent inputs are compared, so N inputs give N-1 response bits. When the window closes, the enable drops so that the oscillators rest between runs. The result then appears together with a one-cycle done pulse.

Top module: `osc_puf_resp`

## Requirements
- R1: The osc_en output is low after reset. It rises on the clock edge that samples start while the block is idle. It falls on the edge that ends the count window, so it is already low when done is high.
- R2: Let W be win_len, with 0 treated as 1. If start is sampled on rising edge 0, done is high in the cycle that follows rising edge W+2. Rising edges on the inputs are counted during exactly W cycles.
- R3: resp is N-1 bits wide. Bit k is 1 when the edge count of osc_in[k] is strictly greater than the edge count of osc_in[k+1]. Otherwise bit k is 0.
- R4: A toggling input at position k with a held-zero input at position k+1 gives bit k = 1. The reverse placement gives 0.
- R5: Two neighbours that both stay at 0, or that toggle identically, give a response bit of 0.
- R6: Each edge counter saturates at its all-ones value (4095 with the default 12-bit width) and does not wrap. A faster input therefore never compares as slower.
- R7: done is high for exactly one cycle. resp changes only when a new result is formed, and it holds that result until the next measurement completes.
- R8: A start request is ignored while a measurement is in progress. Such a request neither restarts nor lengthens the window, and it produces no extra done pulse.
- R9: After reset, osc_en, done and resp are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Measurement request, sampled while idle |
| win_len | input | WW | Count window length in system cycles |
| osc_in | input | N | Oscillator outputs, toggling or held at 0 |
| osc_en | output | 1 | Registered enable for the oscillator sources |
| resp | output | N-1 | Adjacent-pair comparison result |
| done | output | 1 | One-cycle pulse when resp is updated |

## Verification
A counter that wraps instead of saturating shows up only on long windows, as a fast position that suddenly reads as slower. A fault in the window timer or the state sequence shows at once as a shift in the start-to-done latency, as an enable that stays high, or as a second done pulse after a start sent mid-run. A wrong edge detector or pairing shows on the first done pulse as a flipped bit in a pattern of known frequencies and held-zero inputs.

// File: rtl/osc_puf_resp.sv
module osc_puf_resp #(
  parameter int N  = 8,
  parameter int CW = 12,
  parameter int WW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] win_len,
  input  logic [N-1:0]  osc_in,
  output logic          osc_en,
  output logic [N-2:0]  resp,
  output logic          done
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};
  localparam logic [WW-1:0] WONE = WW'(1);

  typedef enum logic [2:0] {S_IDLE, S_ENABLE, S_COUNT, S_COMPARE, S_DONE} st_t;
  st_t st;

  logic [WW-1:0] win_cnt;
  logic [N-1:0]  sy1, sy2, sy3, rise;
  logic [CW-1:0] cnt [N];
  logic [N-2:0]  cmp;

  wire go = (st == S_IDLE) && start;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= osc_in; sy2 <= sy1; sy3 <= sy2;
    end

  assign rise = sy2 & ~sy3;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      osc_en  <= 1'b0;
      win_cnt <= '0;
      resp    <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_ENABLE;
          osc_en <= 1'b1;
        end
        S_ENABLE: begin
          st      <= S_COUNT;
          win_cnt <= (win_len == '0) ? WONE : win_len;
        end
        S_COUNT: begin
          win_cnt <= win_cnt - WONE;
          if (win_cnt == WONE) begin
            st     <= S_COMPARE;
            osc_en <= 1'b0;
          end
        end
        S_COMPARE: begin
          resp <= cmp;
          st   <= S_DONE;
        end
        default: st <= S_IDLE;
      endcase
    end

  assign done = (st == S_DONE);

  for (genvar k = 0; k < N; k++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                        cnt[k] <= '0;
      else if (go)                                       cnt[k] <= '0;
      else if (st == S_COUNT && rise[k] && cnt[k] != CMAX) cnt[k] <= cnt[k] + 1'b1;

    // R6
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt[k] == CMAX && !go) |=> cnt[k] == CMAX);
  end

  for (genvar k = 0; k < N - 1; k++) begin : g_cmp
    assign cmp[k] = cnt[k] > cnt[k+1];

    // R5
    zero_lose_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == S_COMPARE && cnt[k] == '0) |=> !resp[k]);
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !osc_en);

  // R1
  en_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> $past(st == S_IDLE && start));

  // R7
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(resp) |-> $past(st == S_COMPARE));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st != S_IDLE) |=> st != S_ENABLE);
endmodule

// File: tb/tb_osc_puf_resp.sv
module tb_osc_puf_resp;
  localparam int N = 8, CW = 12, WW = 16;

  logic clk = 0, rst_n = 0, start = 0;
  logic [WW-1:0] win_len = '0;
  logic [N-1:0]  osc = '0;
  wire           osc_en, done;
  wire [N-2:0]   resp;

  int half [N];
  int ph [N];
  int errs = 0, checks = 0;

  osc_puf_resp #(.N(N), .CW(CW), .WW(WW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .win_len(win_len),
    .osc_in(osc), .osc_en(osc_en), .resp(resp), .done(done));

  always #10 clk = ~clk;

  always @(negedge clk)
    for (int k = 0; k < N; k++) begin
      if (!osc_en || half[k] == 0) begin
        osc[k] = 1'b0; ph[k] = 0;
      end else begin
        ph[k] = ph[k] + 1;
        if (ph[k] == half[k]) begin osc[k] = ~osc[k]; ph[k] = 0; end
      end
    end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int w, input int kick, output int lat, output logic [N-2:0] r);
    @(negedge clk); win_len = WW'(w); start = 1;
    @(negedge clk); start = 0; lat = 1;
    chk(osc_en === 1'b1, "R1 enable raised", int'(osc_en), 1);
    while (done !== 1'b1 && lat < 100000) begin
      @(negedge clk); lat++;
      start = (lat == kick);
    end
    start = 0;
    r = resp;
    chk(osc_en === 1'b0, "R1 enable low at done", int'(osc_en), 0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle", int'(done), 0);
  endtask

  task automatic run_case(input string req, input int w, input logic [N-2:0] exp);
    int lat; logic [N-2:0] r;
    measure(w, -1, lat, r);
    chk(lat == ((w == 0 ? 1 : w) + 3), "R2 latency", lat, (w == 0 ? 1 : w) + 3);
    chk(r === exp, req, int'(r), int'(exp));
    repeat (20) @(negedge clk);
    chk(resp === r, "R7 resp held", int'(resp), int'(r));
  endtask

  task automatic t_reset;
    chk(osc_en === 1'b0, "R9 reset osc_en", int'(osc_en), 0);
    chk(done === 1'b0, "R9 reset done", int'(done), 0);
    chk(resp === '0, "R9 reset resp", int'(resp), 0);
  endtask

  task automatic t_descending;
    half = '{2, 3, 4, 5, 6, 7, 8, 9};
    run_case("R3 descending freq", 400, 7'h7F);
  endtask

  task automatic t_ascending;
    half = '{9, 8, 7, 6, 5, 4, 3, 2};
    run_case("R3 ascending freq", 400, 7'h00);
  endtask

  task automatic t_gated;
    half = '{3, 0, 3, 0, 0, 4, 4, 0};
    run_case("R4 R5 gated pattern", 300, 7'b1000101);
  endtask

  task automatic t_saturate;
    half = '{2, 3, 0, 0, 0, 0, 0, 0};
    run_case("R6 saturation", 20000, 7'b0000011);
  endtask

  task automatic t_zero_window;
    half = '{0, 0, 0, 0, 0, 0, 0, 0};
    run_case("R2 zero window", 0, 7'h00);
  endtask

  task automatic t_busy_start;
    int lat, extra; logic [N-2:0] r;
    half = '{2, 3, 4, 5, 6, 7, 8, 9};
    measure(200, 50, lat, r);
    chk(lat == 203, "R8 window not extended", lat, 203);
    chk(r === 7'h7F, "R8 result", int'(r), 127);
    extra = 0;
    repeat (300) begin @(negedge clk); if (done === 1'b1) extra++; end
    chk(extra == 0, "R8 no extra done", extra, 0);
    chk(osc_en === 1'b0, "R8 enable stays low", int'(osc_en), 0);
  endtask

  initial begin
    #(20ns * 190000);
    errs++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < N; k++) begin half[k] = 0; ph[k] = 0; end
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_descending;
    t_ascending;
    t_gated;
    t_zero_window;
    t_busy_start;
    t_saturate;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule